// File: doc/BRIEF.md
# Self-Triggered Reconfiguration Sequencer

This block reloads a group of configurable devices from a dedicated byte-wide configuration store. The store is split into equal slots, and each slot holds one complete board setup. The first bytes of a slot are parameters for a programmable clock generator. The rest of the slot is one unbroken bitstream that feeds three chained devices. The first device takes bytes in parallel, and the other two are loaded serially behind it. A load always reconfigures all three devices together.

A load can be started in two ways. The host can write a slot number, or the user logic running on the devices can ask for a stored slot itself, with no help from the host.

When a request is accepted, the sequencer:
1. Latches the slot number and forms the slot base address.
2. Pulses the devices' program line and waits until they report they are ready.
3. Shifts the clock parameter bytes to the clock generator one bit at a time, then pulses a latch strobe.
4. Streams the bitstream bytes to the parallel configuration port over a valid/ready handshake.

The run ends when the devices raise their done line, which sets the done flag. If every bitstream byte of the slot has been sent and done still has not appeared, the error flag is set instead.

Back-pressure rules on the configuration port:
- Once `cfg_valid` is high, it stays high and `cfg_data` stays unchanged until a cycle in which `cfg_ready` is high. That cycle is the transfer.
- `cfg_ready` may stay low for any number of cycles.
- If `dev_done` is high while a byte is on offer, the byte is withdrawn and not counted.

Top module: `recfg_seq`

## Requirements
- R1: After reset, `busy`, `irq_done`, `irq_err`, `dev_program`, `cfg_valid` and `mem_rd` are 0. An accepted request sets `busy` and clears both flags on the next clock edge. `busy` falls in the same cycle in which one of the flags is set.
- R2: Every store read uses address `{slot, offset}`. The slot base is therefore slot × 2^(ADDR_W−SLOT_W). Offsets are read in rising order from 0, and each offset is read once.
- R3: A run begins with a one-cycle `dev_program` pulse. No store read happens while `dev_ready` is 0.
- R4: Slot offsets 0 to CLK_BYTES−1 go to the clock generator MSB first, one bit per cycle with `ck_shift` high. One `ck_latch` pulse follows the last bit, before any configuration byte is offered.
- R5: Offsets CLK_BYTES and above are offered in order on `cfg_data`. `cfg_valid` is held with stable data until `cfg_ready` is high.
- R6: When `dev_done` is seen during streaming, the run stops, sets `irq_done` and sends no further bytes.
- R7: If `dev_done` is still low one cycle after the last byte of the slot is accepted, `irq_err` is set. In that case exactly 2^(ADDR_W−SLOT_W)−CLK_BYTES bytes have been sent.
- R8: Requests that arrive while `busy` is high are ignored. The slot in use and the data streamed do not change.
- R9: `user_req` alone starts a load of `user_slot`. When `host_wr` and `user_req` arrive in the same cycle, the host's slot is taken.
- R10: `active_slot` shows the slot of the current or most recent load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host slot-select write strobe, starts a load |
| host_slot | input | SLOT_W | Slot written by the host |
| user_req | input | 1 | Reload request from user logic |
| user_slot | input | SLOT_W | Slot requested by user logic |
| busy | output | 1 | Sequence in progress |
| irq_done | output | 1 | Latched completion reason |
| irq_err | output | 1 | Latched failure reason |
| active_slot | output | SLOT_W | Slot of the current or last load |
| mem_rd | output | 1 | Store read strobe; data arrives one cycle later |
| mem_addr | output | ADDR_W | Store read address |
| mem_rdata | input | 8 | Store read data |
| ck_bit | output | 1 | Clock-generator serial data |
| ck_shift | output | 1 | Clock-generator bit strobe |
| ck_latch | output | 1 | Clock-generator parameter latch |
| dev_program | output | 1 | Start-of-configuration pulse to the devices |
| dev_ready | input | 1 | Devices ready to receive data |
| dev_done | input | 1 | Devices report configuration complete |
| cfg_valid | output | 1 | Configuration byte on offer |
| cfg_ready | input | 1 | Configuration port accepts the byte |
| cfg_data | output | 8 | Configuration byte |

## Verification
Each of the four slots is loaded with a store whose content depends on the address. Any error in the base address, the offset order, or the split between clock bytes and stream bytes therefore shows up as a wrong byte value. Random stalls on `cfg_ready` test that data is held under back-pressure.

Three behaviours of `dev_done` separate the two ways a run can end:
- done right after the last byte, which must give `irq_done`;
- done part-way through the stream, which must give `irq_done` and a short byte count;
- done never raised, which must give `irq_err` and a full byte count.

Requests made in the middle of a run, and host and user requests made in the same cycle, test the ignore rule and the priority rule.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_WRDY,
    ST_RD,
    ST_CAP,
    ST_SHIFT,
    ST_LATCH,
    ST_PUSH,
    ST_CHK
  } seq_state_e;
endpackage

// File: rtl/recfg_shift.sv
module recfg_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              bit_o,
  output logic              shift_o,
  output logic              idle_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= din;
      cnt_q <= CNT_W'(BYTE_W);
    end else if (cnt_q != '0) begin
      sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_o   = sh_q[BYTE_W-1];
  assign shift_o = (cnt_q != '0);
  assign idle_o  = (cnt_q == '0);
endmodule

// File: rtl/recfg_addr.sv
module recfg_addr #(
  parameter int ADDR_W    = 19,
  parameter int SLOT_W    = 2,
  parameter int CLK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] addr,
  output logic              in_clk,
  output logic              clk_end,
  output logic              last
);
  localparam int OFF_W = ADDR_W - SLOT_W;

  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   off_q <= '0;
    else if (clr) off_q <= '0;
    else if (inc) off_q <= off_q + 1'b1;
  end

  assign addr    = {slot, off_q};
  assign in_clk  = (off_q < OFF_W'(CLK_BYTES));
  assign clk_end = (off_q == OFF_W'(CLK_BYTES - 1));
  assign last    = &off_q;
endmodule

// File: rtl/recfg_seq.sv
module recfg_seq
  import recfg_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int SLOT_W    = 2,
  parameter int CLK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [SLOT_W-1:0] host_slot,
  input  logic              user_req,
  input  logic [SLOT_W-1:0] user_slot,
  output logic              busy,
  output logic              irq_done,
  output logic              irq_err,
  output logic [SLOT_W-1:0] active_slot,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              ck_bit,
  output logic              ck_shift,
  output logic              ck_latch,
  output logic              dev_program,
  input  logic              dev_ready,
  input  logic              dev_done,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [7:0]        cfg_data
);
  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q;
  logic [7:0]        byte_q;
  logic              busy_q, done_q, err_q;
  logic              start, fin_ok, fin_err, off_clr, off_inc, sh_load;
  logic              in_clk, clk_end, last, sh_idle;
  logic [SLOT_W-1:0] sel_slot;

  assign start    = (state_q == ST_IDLE) && (host_wr || user_req);
  assign sel_slot = host_wr ? host_slot : user_slot;

  recfg_addr #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .CLK_BYTES(CLK_BYTES)) addr_i (
    .clk(clk), .rst_n(rst_n), .clr(off_clr), .inc(off_inc), .slot(slot_q),
    .addr(mem_addr), .in_clk(in_clk), .clk_end(clk_end), .last(last)
  );

  recfg_shift #(.BYTE_W(8)) shift_i (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .din(mem_rdata),
    .bit_o(ck_bit), .shift_o(ck_shift), .idle_o(sh_idle)
  );

  always_comb begin
    state_d = state_q;
    fin_ok  = 1'b0;
    fin_err = 1'b0;
    off_clr = 1'b0;
    off_inc = 1'b0;
    sh_load = 1'b0;
    mem_rd  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        off_clr = 1'b1;
        state_d = ST_PROG;
      end
      ST_PROG: state_d = ST_WRDY;
      ST_WRDY: if (dev_ready) state_d = ST_RD;
      ST_RD: begin
        if (dev_done && !in_clk) begin
          fin_ok  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          mem_rd  = 1'b1;
          state_d = ST_CAP;
        end
      end
      ST_CAP: begin
        if (in_clk) begin
          sh_load = 1'b1;
          state_d = ST_SHIFT;
        end else begin
          state_d = ST_PUSH;
        end
      end
      ST_SHIFT: if (sh_idle) begin
        off_inc = 1'b1;
        state_d = clk_end ? ST_LATCH : ST_RD;
      end
      ST_LATCH: state_d = ST_RD;
      ST_PUSH: begin
        if (dev_done) begin
          fin_ok  = 1'b1;
          state_d = ST_IDLE;
        end else if (cfg_ready) begin
          off_inc = 1'b1;
          state_d = last ? ST_CHK : ST_RD;
        end
      end
      ST_CHK: begin
        fin_ok  = dev_done;
        fin_err = !dev_done;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      byte_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) begin
        slot_q <= sel_slot;
        busy_q <= 1'b1;
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (fin_ok || fin_err) busy_q <= 1'b0;
      if (fin_ok)  done_q <= 1'b1;
      if (fin_err) err_q  <= 1'b1;
      if (state_q == ST_CAP) byte_q <= mem_rdata;
    end
  end

  assign busy        = busy_q;
  assign irq_done    = done_q;
  assign irq_err     = err_q;
  assign active_slot = slot_q;
  assign dev_program = (state_q == ST_PROG);
  assign ck_latch    = (state_q == ST_LATCH);
  assign cfg_valid   = (state_q == ST_PUSH);
  assign cfg_data    = byte_q;
endmodule

// File: rtl/recfg_seq_chk.sv
module recfg_seq_chk #(
  parameter int ADDR_W = 19,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              irq_done,
  input logic              irq_err,
  input logic [SLOT_W-1:0] active_slot,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ck_shift,
  input logic              dev_program,
  input logic              dev_done,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [7:0]        cfg_data
);
  AST_BUSY_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!irq_done && !irq_err)); // R1
  AST_ADDR_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[ADDR_W-1 -: SLOT_W] == active_slot)); // R2
  AST_NO_READ_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    dev_program |=> !mem_rd); // R3
  AST_SHIFT_NOT_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(ck_shift && cfg_valid)); // R4
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready && !dev_done) |=> (cfg_valid && $stable(cfg_data))); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_done && irq_err)); // R7
  AST_SLOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(active_slot)); // R8
endmodule

bind recfg_seq recfg_seq_chk #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq_done(irq_done), .irq_err(irq_err),
  .active_slot(active_slot), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .ck_shift(ck_shift), .dev_program(dev_program), .dev_done(dev_done),
  .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data)
);

// File: tb/recfg_seq_tb.sv
module recfg_seq_tb_top;
  localparam int ADDR_W    = 8;
  localparam int SLOT_W    = 2;
  localparam int CLK_BYTES = 16;
  localparam int SLOT_B    = 1 << (ADDR_W - SLOT_W);
  localparam int STREAM_B  = SLOT_B - CLK_BYTES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, user_req = 1'b0, cfg_ready = 1'b0;
  logic [SLOT_W-1:0] host_slot = '0, user_slot = '0;
  logic busy, irq_done, irq_err, mem_rd, ck_bit, ck_shift, ck_latch;
  logic dev_program, cfg_valid;
  logic [SLOT_W-1:0] active_slot;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_rdata = '0, cfg_data;
  logic dev_ready = 1'b0, dev_done = 1'b0;

  always #2 clk = ~clk;

  recfg_seq #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .CLK_BYTES(CLK_BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_slot(host_slot),
    .user_req(user_req), .user_slot(user_slot), .busy(busy), .irq_done(irq_done),
    .irq_err(irq_err), .active_slot(active_slot), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .ck_bit(ck_bit), .ck_shift(ck_shift), .ck_latch(ck_latch),
    .dev_program(dev_program), .dev_ready(dev_ready), .dev_done(dev_done),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data)
  );

  int errors = 0, checks = 0;
  int dev_k = 0;

  function automatic logic [7:0] exp_byte(input int a);
    return 8'((a * 29 + (a >> 3) + 90) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // store, device and observation models
  int rdy_wait = 0, dcnt = 0;
  int rx_n = 0, rx_bad = 0, ck_nbits = 0, ck_bad = 0, latch_n = 0, order_bad = 0;
  int rd_n = 0, addr_bad = 0, rd_early = 0, prog_total = 0, rd_slot = 0;
  logic [7:0] ck_cur = '0;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= exp_byte(int'(mem_addr));
    if (dev_program) begin
      prog_total <= prog_total + 1;
      dev_ready <= 1'b0; dev_done <= 1'b0; dcnt <= 0; rdy_wait <= 3;
      rx_n <= 0; rx_bad <= 0; ck_nbits <= 0; ck_bad <= 0; latch_n <= 0;
      order_bad <= 0; rd_n <= 0; addr_bad <= 0; rd_early <= 0;
    end else begin
      if (rdy_wait != 0) begin
        rdy_wait <= rdy_wait - 1;
        if (rdy_wait == 1) dev_ready <= 1'b1;
      end
      if (mem_rd) begin
        if (!dev_ready) rd_early <= rd_early + 1;
        if (rd_n == 0) rd_slot <= int'(mem_addr) / SLOT_B;
        else if (int'(mem_addr) / SLOT_B != rd_slot) addr_bad <= addr_bad + 1;
        if (int'(mem_addr) % SLOT_B != rd_n) addr_bad <= addr_bad + 1;
        rd_n <= rd_n + 1;
      end
      if (ck_shift) begin
        ck_cur <= {ck_cur[6:0], ck_bit};
        ck_nbits <= ck_nbits + 1;
        if (ck_nbits % 8 == 7 &&
            {ck_cur[6:0], ck_bit} != exp_byte(int'(active_slot) * SLOT_B + ck_nbits / 8))
          ck_bad <= ck_bad + 1;
      end
      if (ck_latch) latch_n <= latch_n + 1;
      if (cfg_valid && cfg_ready && !dev_done) begin
        if (latch_n == 0) order_bad <= order_bad + 1;
        if (cfg_data != exp_byte(int'(active_slot) * SLOT_B + CLK_BYTES + rx_n))
          rx_bad <= rx_bad + 1;
        rx_n <= rx_n + 1;
        dcnt <= dcnt + 1;
        if (dev_k != 0 && dcnt + 1 == dev_k) dev_done <= 1'b1;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    forever begin
      @(negedge clk);
      cfg_ready = ($urandom % 4) != 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic run_load(input bit hw, input bit ur, input int hs, input int us,
                          input int k, input int want, input bit mid, input string tag);
    int p0;
    int n;
    int expn;
    p0 = prog_total;
    dev_k = k;
    @(negedge clk);
    host_wr = hw; user_req = ur;
    host_slot = SLOT_W'(hs); user_slot = SLOT_W'(us);
    @(negedge clk);
    host_wr = 1'b0; user_req = 1'b0;
    chk(busy && !irq_done && !irq_err, {tag, " R1 busy set, flags cleared"}, int'(busy), 1);
    chk(int'(active_slot) == want, {tag, " R9 R10 slot taken"}, int'(active_slot), want);
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
      if (mid && n == 60) begin
        host_wr = 1'b1; user_req = 1'b1;
        host_slot = SLOT_W'(want + 1); user_slot = SLOT_W'(want + 2);
      end else begin
        host_wr = 1'b0; user_req = 1'b0;
      end
    end
    expn = (k == 0) ? STREAM_B : k;
    chk(!busy, {tag, " R1 busy cleared"}, int'(busy), 0);
    chk(irq_done == (k != 0), {tag, " R6 done flag"}, int'(irq_done), int'(k != 0));
    chk(irq_err == (k == 0), {tag, " R7 error flag"}, int'(irq_err), int'(k == 0));
    chk(rx_n == expn, {tag, " R5 R6 R7 byte count"}, rx_n, expn);
    chk(rx_bad == 0, {tag, " R5 stream bytes"}, rx_bad, 0);
    chk(ck_nbits == CLK_BYTES * 8 && ck_bad == 0, {tag, " R4 clock bits"}, ck_nbits, CLK_BYTES * 8);
    chk(latch_n == 1 && order_bad == 0, {tag, " R4 latch before stream"}, latch_n, 1);
    chk(addr_bad == 0 && rd_slot == want, {tag, " R2 read addresses"}, addr_bad, 0);
    chk(rd_early == 0, {tag, " R3 read before ready"}, rd_early, 0);
    chk(prog_total - p0 == 1, {tag, " R3 R8 program pulses"}, prog_total - p0, 1);
    chk(int'(active_slot) == want, {tag, " R8 R10 slot kept"}, int'(active_slot), want);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !irq_done && !irq_err && !dev_program && !cfg_valid && !mem_rd,
        "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_load(1, 0, 1, 0, STREAM_B, 1, 0, "host slot1 full");
    run_load(0, 1, 0, 3, 20, 3, 0, "user slot3 early done");
    run_load(1, 0, 2, 0, 0, 2, 0, "host slot2 no done");
    run_load(1, 0, 0, 0, STREAM_B, 0, 1, "R8 mid-run requests");
    run_load(1, 1, 1, 2, STREAM_B, 1, 0, "R9 simultaneous");
    for (int i = 0; i < 5; i++) begin
      int s;
      int k;
      int src;
      s = int'($urandom % 4);
      src = int'($urandom % 2);
      k = int'($urandom % 3);
      k = (k == 0) ? 0 : (k == 1) ? STREAM_B : 1 + int'($urandom % (STREAM_B - 1));
      run_load(src == 0, src == 1, s, s, k, s, 0, "random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule